// File: doc/BRIEF.md
# Prioritized Conversion Request Arbiter

This block decides which analog channel a single converter samples next. It holds two request sources. The parallel source is a bitmask of channels that become pending together when it is triggered. The queued source is a small FIFO of channel numbers that software loads in the order it wants them served. Each source has a programmable priority level. Each source can be armed by an internal or an external trigger input, and each input has its own enable bit. A one-off insertion request can also place a single channel ahead of both sources without disturbing the sequence that is running.

Whenever the converter is idle and something is pending, the arbiter picks the winning source. It issues a one-cycle start pulse with the channel number and a source code, then waits for the converter's done pulse before it arbitrates again. A conversion that has started is never abandoned.

Top module: `conv_req_arbiter`

## Requirements
- R1: After reset, conv_start is 0, par_pend is all zero, q_count is 0 and q_ovf is 0.
- R2: A parallel trigger fires on par_trig_int when par_trig_en[0] is 1, or on par_trig_ext when par_trig_en[1] is 1. When it fires, par_mask is ORed into par_pend. A trigger pulse whose enable bit is 0 leaves par_pend unchanged.
- R3: The parallel source serves its pending channels from the highest-numbered down. A channel's par_pend bit clears on the clock edge that issues it.
- R4: The queued source issues channels in the order they were written with q_wr. An entry leaves the queue, and q_count drops, on the edge that issues it.
- R5: A q_wr while q_count equals QDEPTH is dropped. It sets q_ovf, which stays 1 until reset. q_count never exceeds QDEPTH.
- R6: When both sources are eligible, the one with the larger priority value wins. On equal values the queued source wins.
- R7: An ins_req that arrives while no insertion is waiting records ins_ch. That channel is issued next, ahead of both sources, with conv_src = 2. The interrupted sequence then resumes with no channel skipped or repeated.
- R8: conv_start is a one-cycle pulse, issued one edge after the converter is idle with a request pending. No further pulse is issued until conv_done has been seen. conv_src encodes 0 for parallel, 1 for queued and 2 for insertion.
- R9: The queued source is eligible only after a queue trigger fires. A queue trigger fires on q_trig_int with q_trig_en[0] = 1, or on q_trig_ext with q_trig_en[1] = 1. The queue stays armed until its last entry is issued. Entries written before the trigger wait and are not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_prio | input | PRIW | Priority level of the parallel source |
| q_prio | input | PRIW | Priority level of the queued source |
| par_mask | input | NCH | Channels made pending by a parallel trigger |
| par_trig_en | input | 2 | Parallel trigger enables: bit 0 internal, bit 1 external |
| par_trig_int | input | 1 | Internal parallel trigger pulse |
| par_trig_ext | input | 1 | External parallel trigger pulse |
| q_wr | input | 1 | Queue write strobe |
| q_wr_ch | input | CHW | Channel written into the queue |
| q_trig_en | input | 2 | Queue trigger enables: bit 0 internal, bit 1 external |
| q_trig_int | input | 1 | Internal queue trigger pulse |
| q_trig_ext | input | 1 | External queue trigger pulse |
| ins_req | input | 1 | One-off insertion request |
| ins_ch | input | CHW | Channel to insert |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | CHW | Channel to convert |
| conv_src | output | 2 | Source of the issued channel |
| par_pend | output | NCH | Pending channels of the parallel source |
| q_count | output | CW | Number of queued entries |
| q_ovf | output | 1 | Sticky queue overflow flag |

## Verification
The hardest case to reach is an insertion that lands in the middle of a parallel sequence. To force it, the bench starts a multi-channel parallel set and holds conv_done low after the first issue. While the converter is still busy, it raises the insertion request and confirms that no new start pulse appears. It then releases the converter and checks the inserted channel followed by the rest of the set in descending order. Priority conflicts are forced by triggering both sources on the same edge while the converter is idle, so both are eligible at the next arbitration.

// File: rtl/conv_req_arbiter.sv
module conv_req_arbiter #(
  parameter int NCH    = 8,
  parameter int QDEPTH = 4,
  parameter int PRIW   = 2,
  localparam int CHW   = $clog2(NCH),
  localparam int CW    = $clog2(QDEPTH + 1),
  localparam int PW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PRIW-1:0] par_prio,
  input  logic [PRIW-1:0] q_prio,
  input  logic [NCH-1:0]  par_mask,
  input  logic [1:0]      par_trig_en,
  input  logic            par_trig_int,
  input  logic            par_trig_ext,
  input  logic            q_wr,
  input  logic [CHW-1:0]  q_wr_ch,
  input  logic [1:0]      q_trig_en,
  input  logic            q_trig_int,
  input  logic            q_trig_ext,
  input  logic            ins_req,
  input  logic [CHW-1:0]  ins_ch,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CHW-1:0]  conv_ch,
  output logic [1:0]      conv_src,
  output logic [NCH-1:0]  par_pend,
  output logic [CW-1:0]   q_count,
  output logic            q_ovf
);

  localparam logic [1:0] SRC_PAR = 2'd0;
  localparam logic [1:0] SRC_Q   = 2'd1;
  localparam logic [1:0] SRC_INS = 2'd2;

  logic           busy;
  logic           q_armed;
  logic           ins_pend;
  logic [CHW-1:0] ins_ch_r;
  logic [CHW-1:0] q_mem [QDEPTH];
  logic [PW-1:0]  rptr, wptr;

  logic           par_fire, q_fire;
  logic           par_hit, q_elig, any_req, grant;
  logic [CHW-1:0] par_sel;
  logic [1:0]     win_src;
  logic [CHW-1:0] win_ch;
  logic           q_full, wr_ok, pop;

  assign par_fire = (par_trig_en[0] & par_trig_int) | (par_trig_en[1] & par_trig_ext);
  assign q_fire   = (q_trig_en[0] & q_trig_int) | (q_trig_en[1] & q_trig_ext);

  assign par_hit = |par_pend;
  assign q_elig  = q_armed && (q_count != '0);
  assign any_req = ins_pend | q_elig | par_hit;
  assign grant   = !busy && any_req;

  always_comb begin
    par_sel = '0;
    for (int i = 0; i < NCH; i++)
      if (par_pend[i]) par_sel = CHW'(i);
  end

  always_comb begin
    if (ins_pend) begin
      win_src = SRC_INS;
      win_ch  = ins_ch_r;
    end else if (q_elig && (!par_hit || q_prio >= par_prio)) begin
      win_src = SRC_Q;
      win_ch  = q_mem[rptr];
    end else begin
      win_src = SRC_PAR;
      win_ch  = par_sel;
    end
  end

  assign q_full = (q_count == CW'(QDEPTH));
  assign wr_ok  = q_wr && !q_full;
  assign pop    = grant && (win_src == SRC_Q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_ch    <= '0;
      conv_src   <= SRC_PAR;
    end else begin
      conv_start <= grant;
      if (grant) begin
        busy     <= 1'b1;
        conv_ch  <= win_ch;
        conv_src <= win_src;
      end else if (conv_done) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_pend <= '0;
    end else begin
      par_pend <= (par_pend & ~((grant && win_src == SRC_PAR) ? (NCH'(1) << par_sel) : '0))
                | (par_fire ? par_mask : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_pend <= 1'b0;
      ins_ch_r <= '0;
    end else if (ins_pend) begin
      if (grant) ins_pend <= 1'b0;
    end else if (ins_req) begin
      ins_pend <= 1'b1;
      ins_ch_r <= ins_ch;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) q_mem[wptr] <= q_wr_ch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr    <= '0;
      wptr    <= '0;
      q_count <= '0;
      q_ovf   <= 1'b0;
      q_armed <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == PW'(QDEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)   rptr <= (rptr == PW'(QDEPTH - 1)) ? '0 : rptr + 1'b1;
      q_count <= q_count + CW'(wr_ok) - CW'(pop);
      if (q_wr && q_full) q_ovf <= 1'b1;
      if (q_fire) q_armed <= 1'b1;
      else if (pop && q_count == CW'(1) && !wr_ok) q_armed <= 1'b0;
    end
  end

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> !conv_start); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R8
  AST_Q_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(QDEPTH)); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    q_wr && q_full |=> q_ovf); // R5
  AST_PAR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && conv_src == SRC_PAR && !$past(par_fire) |-> !par_pend[conv_ch]); // R3
  AST_INS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_pend && !busy |=> conv_start && conv_src == SRC_INS); // R7

endmodule

// File: tb/conv_req_arbiter_tb.sv
module conv_req_arbiter_tb_top;
  localparam int NCH = 8;
  localparam int QD  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] par_prio = 2'd1, q_prio = 2'd1;
  logic [7:0] par_mask = '0;
  logic [1:0] par_trig_en = 2'b01, q_trig_en = 2'b01;
  logic       par_trig_int = 0, par_trig_ext = 0, q_trig_int = 0, q_trig_ext = 0;
  logic       q_wr = 0, ins_req = 0, conv_done = 0;
  logic [2:0] q_wr_ch = '0, ins_ch = '0;
  logic       conv_start;
  logic [2:0] conv_ch;
  logic [1:0] conv_src;
  logic [7:0] par_pend;
  logic [2:0] q_count;
  logic       q_ovf;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  conv_req_arbiter #(.NCH(NCH), .QDEPTH(QD), .PRIW(2)) dut_i (
    .clk, .rst_n, .par_prio, .q_prio, .par_mask, .par_trig_en, .par_trig_int,
    .par_trig_ext, .q_wr, .q_wr_ch, .q_trig_en, .q_trig_int, .q_trig_ext,
    .ins_req, .ins_ch, .conv_done, .conv_start, .conv_ch, .conv_src,
    .par_pend, .q_count, .q_ovf);

  localparam logic [14:0] VEC [6] = '{
    {8'b1000_0001, 4'd2, 3'd7},
    {8'b0000_0001, 4'd1, 3'd0},
    {8'b0101_0100, 4'd3, 3'd6},
    {8'b1111_1111, 4'd8, 3'd7},
    {8'b0010_0110, 4'd3, 3'd5},
    {8'b0001_1000, 4'd2, 3'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_start(output logic [2:0] ch, output logic [1:0] src);
    int n = 0;
    @(negedge clk);
    while (!conv_start && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk(conv_start, "R8 start timeout", conv_start, 1);
    ch = conv_ch;
    src = conv_src;
  endtask

  task automatic done_pulse();
    conv_done = 1;
    @(negedge clk);
    conv_done = 0;
  endtask

  task automatic conv(output logic [2:0] ch, output logic [1:0] src);
    wait_start(ch, src);
    done_pulse();
  endtask

  task automatic par_trig(input logic [7:0] m);
    par_mask = m;
    par_trig_int = 1;
    @(negedge clk);
    par_trig_int = 0;
  endtask

  task automatic qwrite(input logic [2:0] c);
    q_wr = 1;
    q_wr_ch = c;
    @(negedge clk);
    q_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] ch;
    logic [1:0] src;
    logic [7:0] rem;
    int exp_ch;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(conv_start == 0, "R1 conv_start", conv_start, 0);
    chk(par_pend == 0, "R1 par_pend", par_pend, 0);
    chk(q_count == 0, "R1 q_count", q_count, 0);
    chk(q_ovf == 0, "R1 q_ovf", q_ovf, 0);

    // R3: table of masks, highest channel first
    for (int v = 0; v < 6; v++) begin
      par_trig(VEC[v][14:7]);
      rem = VEC[v][14:7];
      for (int k = 0; k < int'(VEC[v][6:3]); k++) begin
        exp_ch = 0;
        for (int b = 0; b < 8; b++) if (rem[b]) exp_ch = b;
        conv(ch, src);
        if (k == 0) chk(ch == VEC[v][2:0], "R3 first channel", ch, VEC[v][2:0]);
        chk(ch == exp_ch && src == 2'd0, "R3 order", ch, exp_ch);
        rem[exp_ch] = 1'b0;
      end
      repeat (2) @(negedge clk);
      chk(par_pend == 0, "R3 pending cleared", par_pend, 0);
    end

    // R2: disabled trigger has no effect, external enable works
    par_trig_en = 2'b10;
    par_trig(8'h0C);
    repeat (3) @(negedge clk);
    chk(par_pend == 0, "R2 disabled int trigger", par_pend, 0);
    chk(conv_start == 0, "R2 no start", conv_start, 0);
    par_trig_ext = 1;
    @(negedge clk);
    par_trig_ext = 0;
    chk(par_pend == 8'h0C, "R2 ext trigger", par_pend, 8'h0C);
    conv(ch, src);
    chk(ch == 3, "R2 first", ch, 3);
    conv(ch, src);
    chk(ch == 2, "R2 second", ch, 2);
    par_trig_en = 2'b01;

    // R9 and R4: queue waits for trigger, then FIFO order
    qwrite(3); qwrite(1); qwrite(6);
    repeat (4) @(negedge clk);
    chk(conv_start == 0, "R9 unarmed queue idle", conv_start, 0);
    chk(q_count == 3, "R4 q_count", q_count, 3);
    q_trig_int = 1;
    @(negedge clk);
    q_trig_int = 0;
    conv(ch, src); chk(ch == 3 && src == 1, "R4 entry0", ch, 3);
    conv(ch, src); chk(ch == 1 && src == 1, "R4 entry1", ch, 1);
    conv(ch, src); chk(ch == 6 && src == 1, "R4 entry2", ch, 6);
    chk(q_count == 0, "R4 drained", q_count, 0);

    // R9: disarmed after draining
    qwrite(5);
    repeat (4) @(negedge clk);
    chk(conv_start == 0 && q_count == 1, "R9 disarmed after drain", q_count, 1);
    q_trig_int = 1; @(negedge clk); q_trig_int = 0;
    conv(ch, src); chk(ch == 5, "R9 rearmed", ch, 5);

    // R5: overflow
    qwrite(2); qwrite(4); qwrite(5); qwrite(7);
    chk(q_ovf == 0, "R5 no ovf when just full", q_ovf, 0);
    qwrite(0);
    chk(q_ovf == 1, "R5 ovf set", q_ovf, 1);
    chk(q_count == 4, "R5 count capped", q_count, 4);
    q_trig_int = 1; @(negedge clk); q_trig_int = 0;
    conv(ch, src); chk(ch == 2, "R5 kept0", ch, 2);
    conv(ch, src); chk(ch == 4, "R5 kept1", ch, 4);
    conv(ch, src); chk(ch == 5, "R5 kept2", ch, 5);
    conv(ch, src); chk(ch == 7, "R5 kept3", ch, 7);
    repeat (4) @(negedge clk);
    chk(conv_start == 0 && q_count == 0, "R5 dropped entry absent", q_count, 0);
    chk(q_ovf == 1, "R5 ovf sticky", q_ovf, 1);

    // R6: parallel higher priority
    par_prio = 2'd2; q_prio = 2'd1;
    qwrite(1);
    par_mask = 8'h40;
    par_trig_int = 1; q_trig_int = 1;
    @(negedge clk);
    par_trig_int = 0; q_trig_int = 0;
    conv(ch, src); chk(ch == 6 && src == 0, "R6 higher par wins", ch, 6);
    conv(ch, src); chk(ch == 1 && src == 1, "R6 queue next", ch, 1);

    // R6: equal priority favours queue
    par_prio = 2'd1; q_prio = 2'd1;
    qwrite(2);
    par_mask = 8'h20;
    par_trig_int = 1; q_trig_int = 1;
    @(negedge clk);
    par_trig_int = 0; q_trig_int = 0;
    conv(ch, src); chk(ch == 2 && src == 1, "R6 tie to queue", ch, 2);
    conv(ch, src); chk(ch == 5 && src == 0, "R6 par after tie", ch, 5);

    // R7 and R8: insertion during running parallel sequence
    par_trig(8'hB0);
    wait_start(ch, src);
    chk(ch == 7, "R7 seq start", ch, 7);
    ins_req = 1; ins_ch = 2;
    @(negedge clk);
    ins_req = 0;
    repeat (3) begin
      chk(conv_start == 0, "R8 no start while busy", conv_start, 0);
      @(negedge clk);
    end
    done_pulse();
    conv(ch, src); chk(ch == 2 && src == 2, "R7 inserted", ch, 2);
    conv(ch, src); chk(ch == 5 && src == 0, "R7 resume", ch, 5);
    conv(ch, src); chk(ch == 4 && src == 0, "R7 resume last", ch, 4);
    repeat (4) @(negedge clk);
    chk(conv_start == 0 && par_pend == 0, "R7 no repeat", par_pend, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule